// File: doc/BRIEF.md
# Master Interrupt Aggregator with Message-Signalled Delivery

This block sits at the top of an interrupt tree. It takes the pending summary word of each child interrupt group, reduces it to a single level bit, and places that bit at a fixed position in a 32-bit master status word. Bit 31 of the word is the one field software can change. It is the global enable and gates all delivery.

When the global enable is set and at least one summary bit is set, the block asks a bus master to perform one message-signalled interrupt write. The block supplies the target address and the data value. Both come from configuration inputs and are captured when the request is issued. A 16-bit control word decides whether a message may be sent. Bit 0 is the message enable. Any set bit in 15:1 selects a format the block does not support. In that case the block pulses an error flag and sends no request. A request is made once for each rising edge of the combined pending condition. It stays up until the bus master accepts it with a ready signal.

Top module: `msi_master_agg`

## Requirements
- R1: A write stores only bit 31 of `wr_data_i` as the global enable. Bits 30:0 of the write are ignored: the readback of bits 30:0 shows only child-derived values.
- R2: Each child word is reduced with OR over a fixed part of the word and placed at a fixed master bit. The child index is the slice `child_sum_i[32*k +: 32]`. The placements are:
  - child 0: low half to bit 0, high half to bit 1
  - child 1: low half to bit 2, high half to bit 3
  - child 2: low half to bit 4
  - child 3: low half to bit 6
  - children 4, 5 and 6 (whole word) to bits 16, 17 and 18
  - child 7 to bit 20
  - child 8 to bit 22
  - child 9 to bit 23
  - child 10 to bit 30
  - All other master bits read zero.
- R3: Summary bits are level copies. Each one shows its child's state from the previous clock edge, and it sets or clears on every edge. It never latches.
- R4: No request is issued while bit 31 is clear. Setting bit 31 while a summary bit is already set counts as a rising edge of the pending condition.
- R5: When bit 31 is set and any summary bit is set, that condition's rising edge raises `msi_req_o` one cycle later. This happens only when the control word equals bit 0 set with bits 15:1 clear. A condition that stays high gives exactly one request.
- R6: `msi_req_o` stays high until a cycle with `msi_ready_i` high, and drops after that edge. `msi_addr_o` and `msi_data_o` hold the values captured when the request was issued, even if the configuration inputs change. A rising edge that occurs while a request is still outstanding is dropped.
- R7: With control bit 0 clear, a rising edge of the pending condition gives neither a request nor an error.
- R8: With control bit 0 set and any of bits 15:1 set, a rising edge gives a one-cycle `fmt_err_o` pulse, in the cycle a request would have risen, and no request.
- R9: Reset clears the master word, including the enable, along with the request and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Master word write strobe |
| wr_data_i | input | 32 | Write data; only bit 31 is used |
| rd_data_o | output | 32 | Master word readback |
| child_sum_i | input | 352 | Eleven 32-bit child summary words |
| msi_ctrl_i | input | 16 | Message control word |
| msi_addr_i | input | 32 | Message target address |
| msi_data_i | input | 16 | Message data value |
| msi_req_o | output | 1 | Message write request |
| msi_ready_i | input | 1 | Bus master accepts the request |
| msi_addr_o | output | 32 | Captured message address |
| msi_data_o | output | 16 | Captured message data |
| fmt_err_o | output | 1 | Unsupported control format pulse |

## Verification
Random child words are applied with a fixed seed. Many bits are forced to zero so that both halves of each split group are seen set alone, cleared alone, and set together. This separates a wrong half mask from a wrong bit position. Directed single-bit patterns walk each child in turn, to find a summary routed to the wrong master bit. A second set of patterns tries the message side:
- a child that stays high, to tell a one-shot request from a level request;
- enable set after a summary is already pending, to test gating;
- configuration changes while the request is held, to test capture;
- each control word class: disabled, valid, and unsupported.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned MASTER_W = 32;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned NUM_CHILD = 11;

  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_LO   = 2'd1,
    PICK_HI   = 2'd2,
    PICK_ALL  = 2'd3
  } pick_e;

  // which part of which child drives master bit b
  function automatic pick_e bit_pick(int b);
    case (b)
      0, 2, 4, 6:                 return PICK_LO;
      1, 3:                       return PICK_HI;
      16, 17, 18, 20, 22, 23, 30: return PICK_ALL;
      default:                    return PICK_NONE;
    endcase
  endfunction

  function automatic int bit_src(int b);
    case (b)
      0, 1:    return 0;
      2, 3:    return 1;
      4:       return 2;
      6:       return 3;
      16:      return 4;
      17:      return 5;
      18:      return 6;
      20:      return 7;
      22:      return 8;
      23:      return 9;
      30:      return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/msi_agg_sum_map.sv
module msi_agg_sum_map
  import msi_agg_pkg::*;
#(
  parameter int unsigned CHILD_W = 32,
  parameter int unsigned N_CHILD = NUM_CHILD
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CHILD*CHILD_W-1:0] child_i,
  output logic [EN_BIT-1:0]          sum_o
);
  localparam int unsigned HALF_W = CHILD_W / 2;
  localparam logic [CHILD_W-1:0] LO_MASK = {{(CHILD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [EN_BIT-1:0] sum_d;

  for (genvar b = 0; b < EN_BIT; b++) begin : g_bit
    localparam pick_e PICK = bit_pick(b);
    localparam int unsigned SRC = bit_src(b);
    if (PICK == PICK_NONE) begin : g_zero
      assign sum_d[b] = 1'b0;
    end else begin : g_map
      logic [CHILD_W-1:0] mask;
      if (PICK == PICK_LO) begin : g_lo
        assign mask = LO_MASK;
      end else if (PICK == PICK_HI) begin : g_hi
        assign mask = ~LO_MASK;
      end else begin : g_all
        assign mask = '1;
      end
      assign sum_d[b] = |(child_i[SRC*CHILD_W +: CHILD_W] & mask);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= sum_d;
  end
endmodule

// File: rtl/msi_agg_ctrl_reg.sv
module msi_agg_ctrl_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= 1'b0;
    else if (wr_en_i) en_o <= wr_bit_i;
  end

  AST_WR_EN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> en_o == $past(wr_bit_i)); // R1
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_o)); // R1
endmodule

// File: rtl/msi_agg_msi_gen.sv
module msi_agg_msi_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic pend_q;
  logic rise;
  logic fmt_ok;
  logic fmt_bad;

  assign rise    = pend_i & ~pend_q;
  assign fmt_ok  = ctrl_i[0] & ~|ctrl_i[CTRL_W-1:1];
  assign fmt_bad = ctrl_i[0] & |ctrl_i[CTRL_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      req_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      err_o  <= 1'b0;
    end else begin
      pend_q <= pend_i;
      err_o  <= rise & fmt_bad;
      if (req_o) begin
        if (ready_i) req_o <= 1'b0;
      end else if (rise && fmt_ok) begin
        req_o  <= 1'b1;
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ready_i) |=> (req_o && $stable(addr_o) && $stable(data_o))); // R6
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ready_i) |=> !req_o); // R6
  AST_REQ_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(ctrl_i[0] && ctrl_i[CTRL_W-1:1] == '0)); // R5
  AST_REQ_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(pend_i)); // R4
  AST_ERR_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(ctrl_i[0] && ctrl_i[CTRL_W-1:1] != '0) && !$rose(req_o))); // R8
endmodule

// File: rtl/msi_master_agg.sv
module msi_master_agg
  import msi_agg_pkg::*;
#(
  parameter int unsigned CHILD_W = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CTRL_W  = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [MASTER_W-1:0]          wr_data_i,
  output logic [MASTER_W-1:0]          rd_data_o,
  input  logic [NUM_CHILD*CHILD_W-1:0] child_sum_i,
  input  logic [CTRL_W-1:0]            msi_ctrl_i,
  input  logic [ADDR_W-1:0]            msi_addr_i,
  input  logic [DATA_W-1:0]            msi_data_i,
  output logic                         msi_req_o,
  input  logic                         msi_ready_i,
  output logic [ADDR_W-1:0]            msi_addr_o,
  output logic [DATA_W-1:0]            msi_data_o,
  output logic                         fmt_err_o
);
  logic [EN_BIT-1:0] sum_q;
  logic              en_q;
  logic              pend;
  logic              started_q;

  msi_agg_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_bit_i (wr_data_i[EN_BIT]),
    .en_o     (en_q)
  );

  msi_agg_sum_map #(.CHILD_W(CHILD_W), .N_CHILD(NUM_CHILD)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .child_i (child_sum_i),
    .sum_o   (sum_q)
  );

  assign pend      = en_q & |sum_q;
  assign rd_data_o = {en_q, sum_q};

  msi_agg_msi_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_msi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend),
    .ctrl_i  (msi_ctrl_i),
    .addr_i  (msi_addr_i),
    .data_i  (msi_data_i),
    .ready_i (msi_ready_i),
    .req_o   (msi_req_o),
    .addr_o  (msi_addr_o),
    .data_o  (msi_data_o),
    .err_o   (fmt_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  AST_LEVEL_SOUTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> rd_data_o[23] == $past(|child_sum_i[9*CHILD_W +: CHILD_W])); // R3
  AST_LEVEL_PIPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> rd_data_o[16] == $past(|child_sum_i[4*CHILD_W +: CHILD_W])); // R2
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[29:24] == '0 && rd_data_o[15:7] == '0 && rd_data_o[5] == 1'b0); // R2
  AST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msi_req_o) |-> $past(rd_data_o[EN_BIT])); // R4
endmodule

// File: tb/msi_master_agg_test.sv
`timescale 1ns/1ps
module msi_master_agg_test;
  localparam int NC = 11;
  localparam int W  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [31:0]    rd_data;
  logic [NC*W-1:0] child = '0;
  logic [15:0]    ctrl = 16'h0001;
  logic [31:0]    addr = '0;
  logic [15:0]    data = '0;
  logic           req;
  logic           ready = 1'b0;
  logic [31:0]    addr_o;
  logic [15:0]    data_o;
  logic           err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  msi_master_agg uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .child_sum_i(child), .msi_ctrl_i(ctrl),
    .msi_addr_i(addr), .msi_data_i(data), .msi_req_o(req),
    .msi_ready_i(ready), .msi_addr_o(addr_o), .msi_data_o(data_o),
    .fmt_err_o(err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [30:0] exp_sum(input logic [NC*W-1:0] c);
    logic [30:0] s = '0;
    s[0]  = |c[0*W +: 16];
    s[1]  = |c[0*W+16 +: 16];
    s[2]  = |c[1*W +: 16];
    s[3]  = |c[1*W+16 +: 16];
    s[4]  = |c[2*W +: 16];
    s[6]  = |c[3*W +: 16];
    s[16] = |c[4*W +: W];
    s[17] = |c[5*W +: W];
    s[18] = |c[6*W +: W];
    s[20] = |c[7*W +: W];
    s[22] = |c[8*W +: W];
    s[23] = |c[9*W +: W];
    s[30] = |c[10*W +: W];
    return s;
  endfunction

  task automatic write_master(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack();
    ready = 1'b1; step(1); ready = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    step(2);
    chk("R9 reset rd", rd_data, 0);
    chk("R9 reset req", req, 0);
    rst_n = 1'b1;
    step(1);

    // R1: only bit 31 sticks
    write_master(32'hFFFF_FFFF);
    chk("R1 write all ones", rd_data, 32'h8000_0000);
    write_master(32'h7FFF_FFFF);
    chk("R1 write low bits", rd_data, 32'h0000_0000);

    // R2: walk each child
    for (int k = 0; k < NC; k++) begin
      child = '0;
      child[k*W + 3] = 1'b1;
      step(1);
      chk($sformatf("R2 child %0d low", k), rd_data, {1'b0, exp_sum(child)});
      child = '0;
      child[k*W + 28] = 1'b1;
      step(1);
      chk($sformatf("R2 child %0d high", k), rd_data, {1'b0, exp_sum(child)});
    end

    // R3: random level tracking with sparse words
    ready = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [NC*W-1:0] c;
      for (int k = 0; k < NC; k++) begin
        logic [31:0] w;
        w = $urandom();
        if ($urandom_range(0, 2) != 0) w &= 32'h0000_8000 << $urandom_range(0, 1) * 8;
        if ($urandom_range(0, 3) == 0) w = '0;
        c[k*W +: W] = w;
      end
      child = c;
      step(1);
      chk("R3 random level", rd_data[30:0], exp_sum(c));
    end
    child = '0;
    step(1);
    chk("R3 cleared", rd_data, 0);
    ready = 1'b0;
    step(3);

    // R5/R6: one-shot request, capture, hold
    ctrl = 16'h0001; addr = 32'hCAFE_0010; data = 16'h4321;
    write_master(32'h8000_0000);
    child[9*W + 5] = 1'b1;
    step(1);
    chk("R5 no req before edge", req, 0);
    step(1);
    chk("R5 req raised", req, 1);
    chk("R6 addr captured", addr_o, 32'hCAFE_0010);
    chk("R6 data captured", data_o, 16'h4321);
    addr = 32'h1111_2222; data = 16'h9999;
    step(3);
    chk("R6 req held", req, 1);
    chk("R6 addr stable", addr_o, 32'hCAFE_0010);
    chk("R6 data stable", data_o, 16'h4321);
    ack();
    chk("R6 req dropped", req, 0);
    step(4);
    chk("R5 level gives one req", req, 0);
    child = '0; step(2);
    child[10*W + 0] = 1'b1;
    step(2);
    chk("R5 second edge req", req, 1);
    chk("R6 new addr", addr_o, 32'h1111_2222);
    ack();

    // R4: gating by enable
    write_master(32'h0);
    child = '0; step(2);
    child[4*W + 1] = 1'b1;
    step(4);
    chk("R4 no req while disabled", req, 0);
    chk("R4 summary still visible", rd_data, 32'h0001_0000);
    write_master(32'h8000_0000);
    chk("R4 one cycle after enable", req, 0);
    step(1);
    chk("R4 req after enable", req, 1);
    ack();

    // R7: message enable clear
    ctrl = 16'h0000;
    child = '0; step(2);
    child[7*W + 9] = 1'b1;
    step(1);
    chk("R7 no err", err, 0);
    step(1);
    chk("R7 no req", req, 0);
    chk("R7 no err later", err, 0);

    // R8: unsupported format
    ctrl = 16'h0003;
    child = '0; step(2);
    child[8*W + 2] = 1'b1;
    step(1);
    chk("R8 err not early", err, 0);
    step(1);
    chk("R8 err pulse", err, 1);
    chk("R8 no req", req, 0);
    step(1);
    chk("R8 err one cycle", err, 0);

    // R9: reset mid-request
    ctrl = 16'h0001;
    child = '0; step(2);
    child[0] = 1'b1;
    step(2);
    chk("R9 req before reset", req, 1);
    rst_n = 1'b0;
    step(1);
    chk("R9 req cleared", req, 0);
    chk("R9 master cleared", rd_data, 0);
    rst_n = 1'b1;
    step(2);
    chk("R9 enable stays clear", rd_data, 32'h0000_0001);
    chk("R9 no req after reset", req, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule